// File: doc/BRIEF.md
# HD Serial Video Transmit Encoder

This block is the parallel transmit path of a 1.485 Gb/s serial HD video link. On every cycle of the 74.25 MHz word clock it takes one 20-bit word. The upper ten bits are the luma channel and the lower ten bits are the chroma channel. An external serializer sends each output word at twenty times the word rate. The bit serializer, the clock multiplier and the line drivers are outside this block.

Each channel looks for its own timing-reference sequences, start-of-active-video (SAV) and end-of-active-video (EAV). It keeps a per-line CRC-18 and writes that checksum into the two words that follow the line-number pair after each EAV. All twenty bits then go through a self-synchronising scrambler and an NRZI encoder in transmit order, with twenty bit-steps per clock. Two enables bypass the CRC stage and the scrambling stage independently. Each enable applies to the word presented in the same cycle.

Top module: `hd_tx_encoder`

## Requirements
- R1: The output word for an input word appears on `dout` exactly two rising clock edges after the edge that captures the input.
- R2: A synchronous active-high reset clears `dout` to zero and clears the scrambler history, the NRZI bit and both CRC registers. The first words after reset are encoded from that all-zero state.
- R3: Each 10-bit channel detects timing sequences on its own. A timing sequence is 0x3FF, 0x000, 0x000 followed by a flag word whose bit 6 is 1 for EAV and 0 for SAV. A channel that carries no timing sequence gets no CRC words, even when the other channel does.
- R4: With `crc_en` high, the third and fourth words after an EAV flag word are replaced in each channel. The third word becomes {~c[8], c[8:0]} and the fourth becomes {~c[17], c[17:9]}, where c is that channel's CRC register.
- R5: Each channel's CRC register is cleared on the SAV flag word. The register then absorbs every word from the one after that flag through the second line-number word. For each word it takes bits 0..9 in order: fb = bit ^ c[17], then c = (c << 1) ^ (fb ? 0x00031 : 0), which is x^18 + x^5 + x^4 + 1.
- R6: With `crc_en` low, every word, including the two checksum positions, passes through the CRC stage unchanged.
- R7: With `scr_en` high, bits are scrambled in transmit order. Transmit step k (0..19) carries word bit (k mod 2)*10 + k/2, so chroma bit 0 goes first, then luma bit 0, and so on. Each step computes s = d ^ s(-4) ^ s(-9). The scrambler history carries over between words.
- R8: The NRZI output of each step is n = s ^ n(-1) and is written back into the same bit position. Descrambling the output with the inverse rule gives back the CRC-stage word.
- R9: With `scr_en` low, the CRC-stage word is output unencoded, and the scrambler history and NRZI bit keep their values.
- R10: Both enables are sampled together with their input word, so they can change from one word to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 74.25 MHz word clock |
| rst | input | 1 | Synchronous reset, active high |
| crc_en | input | 1 | Enables checksum insertion for this word |
| scr_en | input | 1 | Enables scrambling and NRZI for this word |
| din | input | 20 | Luma in bits 19:10, chroma in bits 9:0 |
| dout | output | 20 | Encoded word for the serializer, same bit layout |

## Verification
Random video lines have active samples kept clear of the reserved codes. These lines run under all four enable combinations, so checksum positions can be told apart from pass-through words, and encoded words from bypassed ones. Lines where only the luma channel carries timing sequences show whether each channel detects on its own. A stretch with the enables toggling on every word shows whether each enable is taken with its own word. Descrambling the captured output separates a scrambler fault from an NRZI fault.

// File: rtl/hdtx_pkg.sv
package hdtx_pkg;
   // Role of the current word in the sequence that follows an EAV flag word.
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_LN0  = 3'd1,
      PH_LN1  = 3'd2,
      PH_CR0  = 3'd3,
      PH_CR1  = 3'd4
   } phase_t;

   // Word bit carried by transmit step k when channels are interleaved, lowest channel first.
   function automatic int tx_bit_index(input int k, input int nch, input int chw);
      return (k % nch) * chw + (k / nch);
   endfunction
endpackage

// File: rtl/hdtx_trs_detect.sv
module hdtx_trs_detect #(
   parameter int CH_W    = 10,
   parameter int XYZ_BIT = 6
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [CH_W-1:0]        din,
   output logic                   sav,
   output hdtx_pkg::phase_t       phase
);
   import hdtx_pkg::*;

   localparam logic [CH_W-1:0] ALL_ONES  = '1;
   localparam logic [CH_W-1:0] ALL_ZEROS = '0;

   logic [CH_W-1:0] hist1_q, hist2_q, hist3_q;
   logic            trs_hit;
   logic            eav;
   phase_t          phase_q;

   assign trs_hit = (hist3_q == ALL_ONES) && (hist2_q == ALL_ZEROS) && (hist1_q == ALL_ZEROS);
   assign eav     = trs_hit &&  din[XYZ_BIT];
   assign sav     = trs_hit && !din[XYZ_BIT];
   assign phase   = phase_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist1_q <= '0;
         hist2_q <= '0;
         hist3_q <= '0;
      end else begin
         hist1_q <= din;
         hist2_q <= hist1_q;
         hist3_q <= hist2_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
      end else if (eav) begin
         phase_q <= PH_LN0;
      end else begin
         case (phase_q)
            PH_LN0:  phase_q <= PH_LN1;
            PH_LN1:  phase_q <= PH_CR0;
            PH_CR0:  phase_q <= PH_CR1;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assert_eav_starts_lines_R3: assert property (@(posedge clk) disable iff (rst)
      eav |=> (phase_q == PH_LN0));

   assert_ln1_then_cr0_R4: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_LN1 && !eav) |=> (phase_q == PH_CR0));
endmodule

// File: rtl/hdtx_line_crc.sv
module hdtx_line_crc #(
   parameter int              CH_W     = 10,
   parameter int              CRC_W    = 18,
   parameter logic [CRC_W-1:0] CRC_POLY = 18'h00031
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             crc_en,
   input  logic [CH_W-1:0]  din,
   input  logic             sav,
   input  hdtx_pkg::phase_t phase,
   output logic [CH_W-1:0]  word_q
);
   import hdtx_pkg::*;

   localparam int HALF = CRC_W / 2;

   logic [CRC_W-1:0] crc_q;
   logic             active_q;
   logic [CH_W-1:0]  word_d;

   function automatic logic [CRC_W-1:0] crc_absorb(input logic [CRC_W-1:0] c,
                                                   input logic [CH_W-1:0] w);
      logic [CRC_W-1:0] r;
      logic             fb;
      r = c;
      for (int i = 0; i < CH_W; i++) begin
         fb = w[i] ^ r[CRC_W-1];
         r  = {r[CRC_W-2:0], 1'b0};
         if (fb) r = r ^ CRC_POLY;
      end
      return r;
   endfunction

   always_comb begin
      word_d = din;
      if (crc_en) begin
         if (phase == PH_CR0)      word_d = {~crc_q[HALF-1],  crc_q[HALF-1:0]};
         else if (phase == PH_CR1) word_d = {~crc_q[CRC_W-1], crc_q[CRC_W-1:HALF]};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         crc_q    <= '0;
         active_q <= 1'b0;
         word_q   <= '0;
      end else begin
         word_q <= word_d;
         if (sav) begin
            crc_q    <= '0;
            active_q <= 1'b1;
         end else begin
            if (active_q) crc_q <= crc_absorb(crc_q, din);
            if (phase == PH_LN1) active_q <= 1'b0;
         end
      end
   end

   assert_crc_guard_bit_R4: assert property (@(posedge clk) disable iff (rst)
      (crc_en && phase == PH_CR0) |=> (word_q[CH_W-1] != word_q[CH_W-2]));

   assert_crc_bypass_R6: assert property (@(posedge clk) disable iff (rst)
      !crc_en |=> (word_q == $past(din)));
endmodule

// File: rtl/hdtx_scrambler.sv
module hdtx_scrambler #(
   parameter int NUM_CH  = 2,
   parameter int CH_W    = 10,
   parameter int SCR_LEN = 9,
   parameter int SCR_TAP = 4,
   localparam int WORD_W = NUM_CH * CH_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   import hdtx_pkg::*;

   logic [SCR_LEN-1:0] hist_q, hist_d;
   logic               nrz_q, nrz_d;
   logic [WORD_W-1:0]  enc_d;

   // Twenty serial steps unrolled: hist[0] is the newest scrambled bit.
   always_comb begin
      logic s;
      int   idx;
      hist_d = hist_q;
      nrz_d  = nrz_q;
      enc_d  = din;
      for (int k = 0; k < WORD_W; k++) begin
         idx        = tx_bit_index(k, NUM_CH, CH_W);
         s          = din[idx] ^ hist_d[SCR_TAP-1] ^ hist_d[SCR_LEN-1];
         hist_d     = {hist_d[SCR_LEN-2:0], s};
         nrz_d      = nrz_d ^ s;
         enc_d[idx] = nrz_d;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_q <= '0;
         nrz_q  <= 1'b0;
         dout   <= '0;
      end else if (en) begin
         hist_q <= hist_d;
         nrz_q  <= nrz_d;
         dout   <= enc_d;
      end else begin
         dout   <= din;
      end
   end

   assert_scr_bypass_R9: assert property (@(posedge clk) disable iff (rst)
      !en |=> (dout == $past(din)));

   assert_scr_state_held_R9: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(hist_q) && $stable(nrz_q)));
endmodule

// File: rtl/hd_tx_encoder.sv
module hd_tx_encoder #(
   parameter int              NUM_CH   = 2,
   parameter int              CH_W     = 10,
   parameter int              XYZ_BIT  = 6,
   parameter int              CRC_W    = 18,
   parameter logic [CRC_W-1:0] CRC_POLY = 18'h00031,
   parameter int              SCR_LEN  = 9,
   parameter int              SCR_TAP  = 4,
   localparam int             WORD_W   = NUM_CH * CH_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              crc_en,
   input  logic              scr_en,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   import hdtx_pkg::*;

   if (CRC_W != 2 * (CH_W - 1)) begin : g_bad_crc_w
      $error("CRC width must fill two checksum words of CH_W-1 bits");
   end
   if (SCR_TAP >= SCR_LEN || SCR_TAP < 1) begin : g_bad_tap
      $error("scrambler tap must lie inside the register");
   end
   if (XYZ_BIT >= CH_W) begin : g_bad_xyz
      $error("flag bit outside the channel word");
   end

   logic [WORD_W-1:0] crc_word;
   logic              scr_en_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic   ch_sav;
      phase_t ch_phase;

      hdtx_trs_detect #(.CH_W(CH_W), .XYZ_BIT(XYZ_BIT)) u_trs (
         .clk   (clk),
         .rst   (rst),
         .din   (din[c*CH_W +: CH_W]),
         .sav   (ch_sav),
         .phase (ch_phase)
      );

      hdtx_line_crc #(.CH_W(CH_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
         .clk    (clk),
         .rst    (rst),
         .crc_en (crc_en),
         .din    (din[c*CH_W +: CH_W]),
         .sav    (ch_sav),
         .phase  (ch_phase),
         .word_q (crc_word[c*CH_W +: CH_W])
      );
   end

   // Scrambler enable travels with its word through the first stage.
   always_ff @(posedge clk) begin
      if (rst) scr_en_q <= 1'b0;
      else     scr_en_q <= scr_en;
   end

   hdtx_scrambler #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_scr (
      .clk  (clk),
      .rst  (rst),
      .en   (scr_en_q),
      .din  (crc_word),
      .dout (dout)
   );
endmodule

// File: tb/hd_tx_encoder_test.sv
module hd_tx_encoder_test;
   localparam int NW = 1800;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        crc_en = 1'b0;
   logic        scr_en = 1'b0;
   logic [19:0] din = '0;
   logic [19:0] dout;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [19:0] stim [NW];
   bit          ce_a [NW];
   bit          se_a [NW];
   string       tg   [NW];
   logic [19:0] exp_crc [NW];
   logic [19:0] exp_out [NW];
   int          wp = 0;

   bit    cur_ce, cur_se, rnd_en;
   string cur_ovr = "";

   logic [8:0] dh = '0;
   bit         dnp = 1'b0;

   always #2.5 clk = ~clk;

   hd_tx_encoder uut (
      .clk(clk), .rst(rst), .crc_en(crc_en), .scr_en(scr_en), .din(din), .dout(dout)
   );

   task automatic chk(input logic [19:0] act, input logic [19:0] exp, input string t);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", t, act, exp);
      end
   endtask

   function automatic logic [9:0] rs();
      return 10'(4 + $urandom_range(0, 1015));
   endfunction

   task automatic put(input logic [9:0] y, input logic [9:0] cb, input string t);
      stim[wp] = {y, cb};
      ce_a[wp] = rnd_en ? 1'($urandom_range(0, 1)) : cur_ce;
      se_a[wp] = rnd_en ? 1'($urandom_range(0, 1)) : cur_se;
      if (rnd_en)              tg[wp] = "R10";
      else if (cur_ovr != "")  tg[wp] = cur_ovr;
      else if (t != "")        tg[wp] = t;
      else                     tg[wp] = se_a[wp] ? "R7" : "R9";
      wp++;
   endtask

   // One video line; chroma_trs=0 leaves the chroma channel without timing sequences (R3).
   task automatic line(input int alen, input bit chroma_trs);
      string t0, t1;
      put(10'h3FF, chroma_trs ? 10'h3FF : rs(), "");
      put(10'h000, chroma_trs ? 10'h000 : rs(), "");
      put(10'h000, chroma_trs ? 10'h000 : rs(), "");
      put(10'h200, chroma_trs ? 10'h200 : rs(), "");
      for (int i = 0; i < alen; i++) put(rs(), rs(), "");
      put(10'h3FF, chroma_trs ? 10'h3FF : rs(), "");
      put(10'h000, chroma_trs ? 10'h000 : rs(), "");
      put(10'h000, chroma_trs ? 10'h000 : rs(), "");
      put(10'h274, chroma_trs ? 10'h274 : rs(), "");
      put(rs(), rs(), "");
      put(rs(), rs(), "");
      t0 = !chroma_trs ? "R3" : (cur_ce ? "R4" : "R6");
      t1 = !chroma_trs ? "R3" : (cur_ce ? "R5" : "R6");
      put(rs(), rs(), t0);
      put(rs(), rs(), t1);
      for (int i = 0; i < 8; i++) put(rs(), rs(), "");
   endtask

   task automatic segment(input bit c, input bit s, input int n, input bit chroma_trs);
      cur_ce = c;
      cur_se = s;
      for (int i = 0; i < n; i++) line(16 + $urandom_range(0, 24), chroma_trs);
   endtask

   function automatic logic [17:0] crc_word10(input logic [17:0] c, input logic [9:0] w);
      logic [17:0] r;
      bit          fb;
      r = c;
      for (int b = 0; b < 10; b++) begin
         fb = w[b] ^ r[17];
         r  = {r[16:0], 1'b0} ^ (fb ? 18'h00031 : 18'h0);
      end
      return r;
   endfunction

   task automatic build_expected();
      int          ph [2];
      bit          act [2];
      logic [17:0] cr [2];
      logic [9:0]  h1 [2], h2 [2], h3 [2];
      logic [8:0]  sh;
      bit          np, trs, s;
      logic [9:0]  w, o;
      int          idx;
      for (int c = 0; c < 2; c++) begin
         ph[c] = 0; act[c] = 0; cr[c] = '0; h1[c] = '0; h2[c] = '0; h3[c] = '0;
      end
      sh = '0;
      np = 1'b0;
      for (int j = 0; j < wp; j++) begin
         for (int c = 0; c < 2; c++) begin
            w   = stim[j][c*10 +: 10];
            trs = (h3[c] == 10'h3FF) && (h2[c] == 10'h0) && (h1[c] == 10'h0);
            o   = w;
            if (ce_a[j] && ph[c] == 3) o = {~cr[c][8],  cr[c][8:0]};
            if (ce_a[j] && ph[c] == 4) o = {~cr[c][17], cr[c][17:9]};
            if (act[c]) cr[c] = crc_word10(cr[c], w);
            if (ph[c] == 2) act[c] = 0;
            if (trs && !w[6]) begin cr[c] = '0; act[c] = 1; end
            if (trs && w[6])     ph[c] = 1;
            else if (ph[c] == 4) ph[c] = 0;
            else if (ph[c] != 0) ph[c] = ph[c] + 1;
            h3[c] = h2[c]; h2[c] = h1[c]; h1[c] = w;
            exp_crc[j][c*10 +: 10] = o;
         end
         exp_out[j] = exp_crc[j];
         if (se_a[j]) begin
            for (int k = 0; k < 20; k++) begin
               idx = (k % 2 == 0) ? k / 2 : 10 + k / 2;
               s   = exp_crc[j][idx] ^ sh[3] ^ sh[8];
               sh  = {sh[7:0], s};
               np  = np ^ s;
               exp_out[j][idx] = np;
            end
         end
      end
   endtask

   // Inverse of the line code applied to the captured output (R8).
   task automatic descramble_check(input int j);
      logic [19:0] rec;
      bit          n, s;
      int          idx;
      rec = '0;
      for (int k = 0; k < 20; k++) begin
         idx      = (k % 2 == 0) ? k / 2 : 10 + k / 2;
         n        = dout[idx];
         s        = n ^ dnp;
         dnp      = n;
         rec[idx] = s ^ dh[3] ^ dh[8];
         dh       = {dh[7:0], s};
      end
      chk(rec, exp_crc[j], "R8 descramble");
   endtask

   initial begin
      void'($urandom(32'h00C0FFEE));
      rnd_en  = 0;
      cur_ovr = "R2";
      segment(1, 1, 1, 1);
      cur_ovr = "";
      segment(1, 1, 5, 1);
      segment(0, 1, 3, 1);
      segment(1, 0, 3, 1);
      cur_ovr = "R1";
      segment(0, 0, 1, 1);
      cur_ovr = "";
      segment(0, 0, 2, 1);
      segment(1, 1, 2, 0);
      segment(1, 0, 1, 0);
      rnd_en = 1;
      segment(1, 1, 4, 1);
      rnd_en = 0;
      segment(1, 1, 3, 1);
      build_expected();

      repeat (3) begin
         @(negedge clk);
         chk(dout, 20'h0, "R2 reset");
      end
      for (int i = 0; i < wp + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            chk(dout, exp_out[i-2], tg[i-2]);
            if (se_a[i-2]) descramble_check(i - 2);
         end
         rst = 1'b0;
         if (i < wp) begin
            din    = stim[i];
            crc_en = ce_a[i];
            scr_en = se_a[i];
         end else begin
            din    = '0;
            crc_en = 1'b0;
            scr_en = 1'b0;
         end
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule